// File: doc/BRIEF.md
# Register-Write Command List Executor

This block runs a list of register-write instructions that software has already placed in memory. Software sets an enable bit and programs a start pointer and an end pointer through a small control/status interface. The run begins when the end pointer is written while the block is enabled and idle. The engine then fetches 32-bit words one at a time from a memory read port. It decodes each 8-byte instruction slot and issues write transactions on a register-write port with a valid/ready handshake. It never reads registers.

Three instruction forms are understood, selected by the opcode byte of the command word. A direct write carries its data word first and its command word second. An indexed write carries a count first, then a command word naming one auto-increment register, then that many data words, all sent to the same register in order. An all-zero slot does nothing, so the zero fill that pads a list out to a 64-byte boundary runs harmlessly. A status flag shows the run in progress. A sticky error flag records an opcode the engine cannot decode, and that opcode also stops the run.

Top module: `cmdlist_exec`

## Requirements
- R1: After reset the status reads 0 (enable, busy and error all clear), both pointers read 0, and neither memRdReq nor regWrValid is asserted.
- R2: Control/status address 0 holds enable in bit 0 (read/write), busy in bit 1 (read-only) and error in bit 2 (cleared by writing 1). Address 1 is the start pointer and address 2 is the end pointer. Both pointers are byte addresses whose low three bits always read 0. Address 3 reads 0.
- R3: A pointer write made while busy is ignored, so the pointer keeps its value.
- R4: Writing the end pointer while enable is 1 and busy is 0 starts a run. Writing it while enable is 0 starts nothing: busy stays 0 and no memory read is made.
- R5: Command word layout: opcode in bits 31:24, byte strobes in bits 23:20, register offset in bits 19:0. Opcode 0x01 (direct) issues exactly one write. Its data is the slot's first word, its address is the offset, and its strobes are bits 23:20.
- R6: Opcode 0x09 (indexed) takes its count N from bits 15:0 of the slot's first word. It then reads N data words and writes each one, in order, to the offset with strobes 0xF. N = 0 issues no write.
- R7: After an indexed write with odd N, the following zero word is skipped without being read, so the next instruction starts on the next 8-byte boundary.
- R8: Opcode 0x00 is a no-op. Both words of the slot are read and no write is issued.
- R9: When the fetch address equals the end pointer at an instruction boundary, the run ends and busy clears. The enable bit is left unchanged. Equal start and end pointers give a run with no memory reads.
- R10: Any other opcode sets the sticky error bit, issues no write and fetches nothing further, and busy clears. Error stays set until software writes 1 to bit 2.
- R11: memRdReq holds with a steady address until memRdValid. regWrValid holds with steady address, data and strobes until regWrReady. The two never overlap. Memory reads go in ascending word order starting at the start pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Control/status write strobe |
| csrAddr | input | 2 | Control/status register select |
| csrWrData | input | 32 | Control/status write data |
| csrRdData | output | 32 | Control/status read data for csrAddr |
| memRdReq | output | 1 | Memory read request, held until memRdValid |
| memRdAddr | output | 16 | Memory byte address of the requested word |
| memRdValid | input | 1 | Memory read data valid; completes the request |
| memRdData | input | 32 | Memory read data |
| regWrValid | output | 1 | Register write request |
| regWrAddr | output | 20 | Register offset |
| regWrData | output | 32 | Register write data |
| regWrStrb | output | 4 | Register write byte strobes |
| regWrReady | input | 1 | Register write accepted |

## Verification
The assertions rely on three things the inputs must do. Memory raises memRdValid only while memRdReq is high. The register side asserts regWrReady only alongside regWrValid. Software never writes a pointer while a run is in flight unless it means to test that the write is dropped. The bench's responders look at the request lines before they answer, so valid and ready only follow a live request. Their wait times vary from zero to two cycles. Every list the bench places in memory is well formed and ends on its 64-byte-rounded end pointer. The only exception is the one slot with a deliberately bad opcode.

// File: rtl/cle_pkg.sv
package cle_pkg;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] CSR_CTRL = 2'd0;
  localparam logic [1:0] CSR_HEAD = 2'd1;
  localparam logic [1:0] CSR_TAIL = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH0,
    S_FETCH1,
    S_DISPATCH,
    S_IDX_RD,
    S_IDX_WR,
    S_WRITE
  } execState_t;

  typedef struct packed {
    logic loadHead;
    logic captureData;
    logic captureCmd;
    logic advance;
    logic loadCount;
    logic decCount;
  } dpStrobes_t;

endpackage

// File: rtl/cle_csr.sv
module cle_csr
  import cle_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csrWrEn,
  input  logic [1:0]    csrAddr,
  input  logic [31:0]   csrWrData,
  output logic [31:0]   csrRdData,
  input  logic          busy,
  input  logic          errSet,
  output logic [AW-1:0] headPtr,
  output logic [AW-1:0] tailPtr,
  output logic          start
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(7);

  logic enableQ;
  logic errQ;
  logic wrCtrl, wrHead, wrTail;
  logic [31-AW:0] unusedWrHigh;

  assign unusedWrHigh = csrWrData[31:AW];
  assign wrCtrl = csrWrEn && (csrAddr == CSR_CTRL);
  assign wrHead = csrWrEn && (csrAddr == CSR_HEAD) && !busy;
  assign wrTail = csrWrEn && (csrAddr == CSR_TAIL) && !busy;
  assign start  = wrTail && enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      errQ    <= 1'b0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (wrCtrl) enableQ <= csrWrData[0];
      if (errSet)
        errQ <= 1'b1;
      else if (wrCtrl && csrWrData[2])
        errQ <= 1'b0;
      if (wrHead) headPtr <= csrWrData[AW-1:0] & ALIGN_MASK;
      if (wrTail) tailPtr <= csrWrData[AW-1:0] & ALIGN_MASK;
    end
  end

  always_comb begin
    case (csrAddr)
      CSR_CTRL: csrRdData = {29'd0, errQ, busy, enableQ};
      CSR_HEAD: csrRdData = {{(32-AW){1'b0}}, headPtr};
      CSR_TAIL: csrRdData = {{(32-AW){1'b0}}, tailPtr};
      default:  csrRdData = 32'd0;
    endcase
  end

  // R3
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(headPtr) && $stable(tailPtr)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !(wrCtrl && csrWrData[2])) |=> errQ);

endmodule

// File: rtl/cle_dpath.sv
module cle_dpath
  import cle_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    stb,
  input  logic [AW-1:0] headPtr,
  input  logic [AW-1:0] tailPtr,
  input  logic [31:0]   memRdData,
  output logic [AW-1:0] fetchAddr,
  output logic [31:0]   dataWord,
  output logic [7:0]    opcode,
  output logic [19:0]   regOffset,
  output logic [3:0]    wrStrb,
  output logic          atTail,
  output logic          wordOdd,
  output logic          countZero,
  output logic          countLast
);

  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [AW-1:0]   addrQ;
  logic [31:0]     dataQ;
  logic [31:0]     cmdQ;
  logic [CNTW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      cmdQ  <= '0;
      cntQ  <= '0;
    end else begin
      if (stb.loadHead)      addrQ <= headPtr;
      else if (stb.advance)  addrQ <= addrQ + WORD_STEP;
      if (stb.captureData)   dataQ <= memRdData;
      if (stb.captureCmd)    cmdQ  <= memRdData;
      if (stb.loadCount)     cntQ  <= dataQ[CNTW-1:0];
      else if (stb.decCount) cntQ  <= cntQ - 1'b1;
    end
  end

  assign fetchAddr = addrQ;
  assign dataWord  = dataQ;
  assign opcode    = cmdQ[31:24];
  assign regOffset = cmdQ[19:0];
  assign wrStrb    = (cmdQ[31:24] == OP_DIRECT) ? cmdQ[23:20] : 4'hF;
  assign atTail    = (addrQ == tailPtr);
  assign wordOdd   = addrQ[2];
  assign countZero = (dataQ[CNTW-1:0] == '0);
  assign countLast = (cntQ == CNTW'(1));

  // R6
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.decCount |-> (cntQ != '0));

  // R11
  addr_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (addrQ[1:0] == 2'b00));

endmodule

// File: rtl/cle_ctrl.sv
module cle_ctrl
  import cle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       atTail,
  input  logic       wordOdd,
  input  logic       countZero,
  input  logic       countLast,
  input  logic [7:0] opcode,
  input  logic       memRdValid,
  input  logic       regWrReady,
  output dpStrobes_t stb,
  output logic       memRdReq,
  output logic       regWrValid,
  output logic       busy,
  output logic       errSet
);

  execState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    stb        = '0;
    memRdReq   = 1'b0;
    regWrValid = 1'b0;
    errSet     = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (start) begin
          stb.loadHead = 1'b1;
          stateD       = S_FETCH0;
        end
      end
      S_FETCH0: begin
        if (atTail) begin
          stateD = S_IDLE;
        end else begin
          memRdReq = 1'b1;
          if (memRdValid) begin
            stb.captureData = 1'b1;
            stb.advance     = 1'b1;
            stateD          = S_FETCH1;
          end
        end
      end
      S_FETCH1: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          stb.captureCmd = 1'b1;
          stb.advance    = 1'b1;
          stateD         = S_DISPATCH;
        end
      end
      S_DISPATCH: begin
        case (opcode)
          OP_NOP:    stateD = S_FETCH0;
          OP_DIRECT: stateD = S_WRITE;
          OP_INDEXED: begin
            if (countZero) begin
              stateD = S_FETCH0;
            end else begin
              stb.loadCount = 1'b1;
              stateD        = S_IDX_RD;
            end
          end
          default: begin
            errSet = 1'b1;
            stateD = S_IDLE;
          end
        endcase
      end
      S_IDX_RD: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          stb.captureData = 1'b1;
          stb.advance     = 1'b1;
          stateD          = S_IDX_WR;
        end
      end
      S_IDX_WR: begin
        regWrValid = 1'b1;
        if (regWrReady) begin
          stb.decCount = 1'b1;
          if (countLast) begin
            stb.advance = wordOdd;
            stateD      = S_FETCH0;
          end else begin
            stateD = S_IDX_RD;
          end
        end
      end
      S_WRITE: begin
        regWrValid = 1'b1;
        if (regWrReady) stateD = S_FETCH0;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid) |=> memRdReq);

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrValid && !regWrReady) |=> regWrValid);

  // R11
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdReq, regWrValid}));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSet |=> !busy);

endmodule

// File: rtl/cmdlist_exec.sv
module cmdlist_exec
  import cle_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csrWrEn,
  input  logic [1:0]    csrAddr,
  input  logic [31:0]   csrWrData,
  output logic [31:0]   csrRdData,
  output logic          memRdReq,
  output logic [AW-1:0] memRdAddr,
  input  logic          memRdValid,
  input  logic [31:0]   memRdData,
  output logic          regWrValid,
  output logic [19:0]   regWrAddr,
  output logic [31:0]   regWrData,
  output logic [3:0]    regWrStrb,
  input  logic          regWrReady
);

  dpStrobes_t    stb;
  logic [AW-1:0] headPtr, tailPtr;
  logic          start, busy, errSet;
  logic          atTail, wordOdd, countZero, countLast;
  logic [7:0]    opcode;

  cle_csr #(.AW(AW)) csrBlk (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .csrWrData(csrWrData),
    .csrRdData(csrRdData),
    .busy(busy), .errSet(errSet),
    .headPtr(headPtr), .tailPtr(tailPtr), .start(start)
  );

  cle_ctrl ctrlBlk (
    .clk(clk), .rstN(rstN), .start(start),
    .atTail(atTail), .wordOdd(wordOdd),
    .countZero(countZero), .countLast(countLast), .opcode(opcode),
    .memRdValid(memRdValid), .regWrReady(regWrReady),
    .stb(stb), .memRdReq(memRdReq), .regWrValid(regWrValid),
    .busy(busy), .errSet(errSet)
  );

  cle_dpath #(.AW(AW), .CNTW(CNTW)) dpathBlk (
    .clk(clk), .rstN(rstN), .stb(stb),
    .headPtr(headPtr), .tailPtr(tailPtr), .memRdData(memRdData),
    .fetchAddr(memRdAddr), .dataWord(regWrData), .opcode(opcode),
    .regOffset(regWrAddr), .wrStrb(regWrStrb),
    .atTail(atTail), .wordOdd(wordOdd),
    .countZero(countZero), .countLast(countLast)
  );

  // R11
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid) |=> $stable(memRdAddr));

  // R11
  wr_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrValid && !regWrReady) |=>
      ($stable(regWrAddr) && $stable(regWrData) && $stable(regWrStrb)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdReq && !regWrValid));

endmodule

// File: tb/cmdlist_exec_test.sv
module cmdlist_exec_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [1:0]  csrAddr = 2'd0;
  logic [31:0] csrWrData = 32'd0;
  logic [31:0] csrRdData;
  logic        memRdReq;
  logic [15:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = 32'd0;
  logic        regWrValid;
  logic [19:0] regWrAddr;
  logic [31:0] regWrData;
  logic [3:0]  regWrStrb;
  logic        regWrReady = 1'b0;

  cmdlist_exec uut (
    .clk(clk), .rstN(rstN),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .csrWrData(csrWrData),
    .csrRdData(csrRdData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .regWrValid(regWrValid), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regWrStrb(regWrStrb),
    .regWrReady(regWrReady)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int readsSeen = 0;
  int writesSeen = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:255];
  int          wp;
  bit          expectOn;
  logic [55:0] expWr[$];
  int          expRd[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory read responder with behavioural expected-address queue
  initial begin
    int rdWait = 0;
    forever begin
      @(negedge clk);
      cycles++;
      memRdValid = 1'b0;
      if (rstN && memRdReq) begin
        if (rdWait == 0) begin
          memRdValid = 1'b1;
          memRdData  = mem[memRdAddr[9:2]];
          readsSeen++;
          if (expRd.size() == 0) begin
            check(1'b0, "R11 unexpected read", 64'(memRdAddr), 64'hFFFF);
          end else begin
            int e;
            e = expRd.pop_front();
            check(memRdAddr == 16'(e), "R11 read address", 64'(memRdAddr), 64'(e));
          end
          rdWait = cycles % 3;
        end else begin
          rdWait--;
        end
      end
    end
  end

  // register write responder with expected-write queue
  initial begin
    int wrWait = 0;
    forever begin
      @(negedge clk);
      regWrReady = 1'b0;
      if (rstN && regWrValid) begin
        if (wrWait == 0) begin
          regWrReady = 1'b1;
          writesSeen++;
          if (expWr.size() == 0) begin
            check(1'b0, "R8/R10 unexpected write",
                  64'({regWrAddr, regWrData, regWrStrb}), 64'd0);
          end else begin
            logic [55:0] e;
            e = expWr.pop_front();
            check({regWrAddr, regWrData, regWrStrb} == e, "R5/R6 write content",
                  64'({regWrAddr, regWrData, regWrStrb}), 64'(e));
          end
          wrWait = (cycles / 2) % 3;
        end else begin
          wrWait--;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(cycles), 64'd0);
    endRun();
  end

  task automatic putWord(input logic [31:0] w, input bit isRead);
    mem[wp[7:0]] = w;
    if (isRead && expectOn) expRd.push_back(wp * 4);
    wp++;
  endtask

  task automatic putDirect(input logic [19:0] off, input logic [31:0] d,
                           input logic [3:0] s);
    putWord(d, 1'b1);
    putWord({8'h01, s, off}, 1'b1);
    if (expectOn) expWr.push_back({off, d, s});
  endtask

  task automatic putIndexed(input logic [19:0] off, input int n,
                            input logic [31:0] base);
    putWord(32'(n), 1'b1);
    putWord({8'h09, 4'h0, off}, 1'b1);
    for (int i = 0; i < n; i++) begin
      putWord(base + 32'(i) * 32'h111, 1'b1);
      if (expectOn) expWr.push_back({off, base + 32'(i) * 32'h111, 4'hF});
    end
    if (n % 2 == 1) putWord(32'd0, 1'b0);
  endtask

  task automatic finishList(output int tailByte);
    tailByte = ((wp * 4 + 63) / 64) * 64;
    while (wp * 4 < tailByte) putWord(32'd0, 1'b1);
  endtask

  task automatic csrWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csrWrEn   = 1'b1;
    csrAddr   = a;
    csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic csrRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csrAddr = a;
    #1 d = csrRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      csrRead(2'd0, v);
      if (!v[1]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int tailB;
    int rdBefore;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1;
    check(memRdReq == 1'b0 && regWrValid == 1'b0, "R1 idle ports",
          64'({memRdReq, regWrValid}), 64'd0);
    rstN = 1'b1;
    csrRead(2'd0, v);
    check(v == 32'd0, "R1 status", 64'(v), 64'd0);
    csrRead(2'd1, v);
    check(v == 32'd0, "R1 head", 64'(v), 64'd0);

    // R2 pointer alignment
    csrWrite(2'd1, 32'h0000_0105);
    csrRead(2'd1, v);
    check(v == 32'h100, "R2 head low bits", 64'(v), 64'h100);
    csrRead(2'd3, v);
    check(v == 32'd0, "R2 unused address", 64'(v), 64'd0);

    // build main list at 0x100
    wp = 64;
    expectOn = 1'b1;
    putDirect(20'h01230, 32'hDEAD_BEEF, 4'hF);
    putIndexed(20'h00400, 3, 32'hA000_0000);
    putIndexed(20'h00500, 2, 32'hB000_0000);
    putWord(32'd0, 1'b1);
    putWord(32'd0, 1'b1);
    putDirect(20'h00678, 32'h0000_55AA, 4'h3);
    putIndexed(20'h00700, 0, 32'd0);
    finishList(tailB);
    expectOn = 1'b0;

    // R4 tail write with enable clear starts nothing
    csrWrite(2'd2, 32'(tailB));
    repeat (5) @(negedge clk);
    csrRead(2'd0, v);
    check(v[1] == 1'b0, "R4 no start when disabled", 64'(v), 64'd0);
    check(readsSeen == 0, "R4 no reads when disabled", 64'(readsSeen), 64'd0);

    // R4 enabled start; R3 pointer writes during run
    csrWrite(2'd0, 32'h1);
    csrWrite(2'd2, 32'(tailB));
    csrWrite(2'd1, 32'h0000_0300);
    csrWrite(2'd2, 32'h0000_0380);
    csrRead(2'd0, v);
    check(v[1] == 1'b1, "R4 busy during run", 64'(v), 64'h3);
    csrRead(2'd1, v);
    check(v == 32'h100, "R3 head kept while busy", 64'(v), 64'h100);
    csrRead(2'd2, v);
    check(v == 32'(tailB), "R3 tail kept while busy", 64'(v), 64'(tailB));
    waitIdle();
    csrRead(2'd0, v);
    check(v == 32'h1, "R9 idle with enable kept", 64'(v), 64'h1);
    check(expWr.size() == 0, "R5/R6/R7 all writes seen", 64'(expWr.size()), 64'd0);
    check(expRd.size() == 0, "R7/R8 all reads seen, padding skipped",
          64'(expRd.size()), 64'd0);
    check(writesSeen == 7, "R6 write count", 64'(writesSeen), 64'd7);

    // R9 equal pointers: no reads
    rdBefore = readsSeen;
    csrWrite(2'd1, 32'h0000_0300);
    csrWrite(2'd2, 32'h0000_0300);
    waitIdle();
    repeat (3) @(negedge clk);
    check(readsSeen == rdBefore, "R9 empty run reads", 64'(readsSeen), 64'(rdBefore));
    csrRead(2'd0, v);
    check(v == 32'h1, "R9 empty run status", 64'(v), 64'h1);

    // R10 bad opcode
    wp = 128;
    expectOn = 1'b1;
    putDirect(20'h00010, 32'h0000_0011, 4'hF);
    putWord(32'h0000_1234, 1'b1);
    putWord(32'h5500_0020, 1'b1);
    expectOn = 1'b0;
    putDirect(20'h00020, 32'h0000_0022, 4'hF);
    finishList(tailB);
    writesSeen = 0;
    csrWrite(2'd1, 32'h0000_0200);
    csrWrite(2'd2, 32'(tailB));
    waitIdle();
    repeat (4) @(negedge clk);
    csrRead(2'd0, v);
    check(v == 32'h5, "R10 error set, busy clear", 64'(v), 64'h5);
    check(writesSeen == 1, "R10 no write after bad opcode", 64'(writesSeen), 64'd1);
    check(expRd.size() == 0, "R10 reads stop at bad slot", 64'(expRd.size()), 64'd0);
    csrWrite(2'd0, 32'h1);
    csrRead(2'd0, v);
    check(v == 32'h5, "R10 error kept without clear bit", 64'(v), 64'h5);
    csrWrite(2'd0, 32'h5);
    csrRead(2'd0, v);
    check(v == 32'h1, "R2 error write-one clear", 64'(v), 64'h1);

    // R7 single-value indexed then direct, after error cleared
    wp = 192;
    expectOn = 1'b1;
    putIndexed(20'h00A00, 1, 32'hC0DE_0001);
    putDirect(20'h00B00, 32'h1357_9BDF, 4'h9);
    finishList(tailB);
    expectOn = 1'b0;
    writesSeen = 0;
    csrWrite(2'd1, 32'h0000_0300);
    csrWrite(2'd2, 32'(tailB));
    waitIdle();
    repeat (3) @(negedge clk);
    check(writesSeen == 2, "R7 writes after padding", 64'(writesSeen), 64'd2);
    check(expRd.size() == 0 && expWr.size() == 0, "R7 queues drained",
          64'(expRd.size() + expWr.size()), 64'd0);
    csrRead(2'd0, v);
    check(v == 32'h1, "R9 final status", 64'(v), 64'h1);

    endRun();
  end

endmodule